// File: doc/BRIEF.md
# Configuration Bitstream Frame Generator

This block turns a stream of frame requests into the serial bit sequence that loads a programmable device. A session starts with a one-cycle start pulse that carries a 24-bit length count, a part identifier, an identifier-enable flag and a parity-enable flag. The generator then emits a header, an optional identifier frame, one data frame per request and a closing trailer. Every frame is followed by a run of stop ones.

Each request carries an 11-bit column address, a compressed flag, a data word and a last flag. An uncompressed frame carries the address, alignment zeros, a write marker and the data. A compressed frame carries the address alone. Two parity bits are computed for every frame. The dummy-one counts are parameters whose legal values keep the stream usable by a byte-wide loader.

The serial output uses a valid/ready handshake, one bit per transfer. A done pulse closes the session.

Top module: `cfg_stream_gen`

## Requirements
- R1: While reset is held, out_valid, req_ready and done are 0 and out_bit is 1.
- R2: The header is LEAD_N ones, then the preamble 0010, then the 24-bit length count MSB first, then TRAIL_N ones. LEAD_N must equal 8n+4, so the byte that ends with the preamble reads 11110010.
- R3: When the identifier is enabled, an identifier frame follows the header. It is made of start 0, P=1, C=0, the two parity bits, eleven ones as the address, the parity-enable bit, 43 zeros and the 20-bit identifier MSB first. When the identifier is disabled, this frame is left out.
- R4: An uncompressed data frame is made of start 0, P=1, C=0, the two parity bits, the 11-bit address MSB first, ALIGN_N zeros, a 1 write marker and DATA_W data bits MSB first.
- R5: A compressed data frame is made of start 0, P=1, C=1, the two parity bits and the 11-bit address, with no alignment, write or data bits.
- R6: The parity bits are sent odd bit first, then even bit. The even bit is the XOR of the covered bits, and the odd bit is its complement. A data frame covers its address, plus its data when uncompressed. The identifier frame covers its address, its parity-enable bit and its identifier. With parity disabled, both bits are 0.
- R7: Every frame is followed by STOP_N ones. After the stop bits of the request marked last, the stream sends 0010011111111111 and then POST_N ones.
- R8: out_bit is 1 whenever out_valid is 0. While out_valid is 1 and out_ready is 0, out_valid and out_bit hold.
- R9: req_ready is 1 only while no bit is pending between frames, after the header and identifier are done. A request is taken when req_valid and req_ready are both 1, and its first bit is valid in the next cycle.
- R10: done pulses for exactly one cycle, one cycle after the last postamble bit is transferred. A start pulse during a session is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Session start pulse, taken only when idle |
| cfg_len | input | 24 | Length count for the header |
| cfg_id_en | input | 1 | Send the identifier frame |
| cfg_id | input | 20 | Part identifier |
| cfg_par_en | input | 1 | Enable parity bits |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Generator waiting for a frame request |
| req_addr | input | 11 | Column address |
| req_comp | input | 1 | Compressed frame (address only) |
| req_last | input | 1 | Final frame of the session |
| req_data | input | DATA_W | Frame data, MSB sent first |
| out_valid | output | 1 | Serial bit valid |
| out_ready | input | 1 | Sink accepts the bit |
| out_bit | output | 1 | Serial bit |
| done | output | 1 | Session finished pulse |

## Verification
The bench builds the block with DATA_W=8, ALIGN_N=3, LEAD_N=12, TRAIL_N=16, STOP_N=8 and POST_N=5. A 12-bit lead puts the preamble byte one byte into the stream, which exercises the 8n+4 rule beyond its smallest case. Short data keeps many sessions cheap, so compressed and uncompressed frames, parity on and off, and identifier on and off all occur under a randomly stalling sink. The small postamble and the three alignment zeros keep the closing sequence and frame boundaries easy to locate.

// File: rtl/cfg_gen_pkg.sv
package cfg_gen_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_LEAD, PH_HDR, PH_TRAIL, PH_ID, PH_IDSTOP,
    PH_WAIT, PH_FRAME, PH_FSTOP, PH_END, PH_POST
  } phase_e;

  localparam int ADDR_W     = 11;
  localparam int LEN_W      = 24;
  localparam int ID_W       = 20;
  localparam int ID_RSV_W   = 43;
  localparam int HEAD_W     = 16;
  localparam int HDR_VEC_W  = 4 + LEN_W;
  localparam int ID_FRAME_W = 5 + ADDR_W + 1 + ID_RSV_W + ID_W;
  localparam int END_W      = 16;

  localparam logic [3:0]        PREAMBLE = 4'b0010;
  localparam logic [END_W-1:0]  END_WORD = 16'b0010011111111111;
  localparam logic [ADDR_W-1:0] ID_ADDR  = '1;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // uncompressed frame length without stop bits
  function automatic int full_frame_len(input int data_w, input int align_n);
    return HEAD_W + align_n + 1 + data_w;
  endfunction

  // {odd, even}; zero when parity disabled
  function automatic logic [1:0] par_pair(input int ones, input logic en);
    logic e;
    e = ((ones % 2) == 1);
    return en ? {~e, e} : 2'b00;
  endfunction

endpackage

// File: rtl/cfg_frame_build.sv
module cfg_frame_build
  import cfg_gen_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ALIGN_N = 2,
  parameter int LEAD_N  = 4,
  parameter int TRAIL_N = 8,
  parameter int STOP_N  = 8,
  parameter int POST_N  = 8,
  parameter int VEC_W   = 80,
  parameter int CNT_W   = 7
) (
  input  phase_e              ph,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [ID_W-1:0]     cfg_id,
  input  logic                cfg_pe,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_comp,
  input  logic [DATA_W-1:0]   req_data,
  output logic [VEC_W-1:0]    vec,
  output logic [CNT_W-1:0]    len,
  output logic                ones
);
  localparam int FULL_W = full_frame_len(DATA_W, ALIGN_N);

  logic [1:0]        id_par;
  logic [1:0]        fr_par;
  logic [HEAD_W-1:0] fr_head;

  always_comb begin
    id_par  = par_pair(ADDR_W + int'(cfg_pe) + $countones(cfg_id), cfg_pe);
    fr_par  = par_pair($countones(req_addr) + (req_comp ? 0 : $countones(req_data)), cfg_pe);
    fr_head = {1'b0, 1'b1, req_comp, fr_par, req_addr};
  end

  always_comb begin
    vec  = '0;
    len  = '0;
    ones = 1'b0;
    unique case (ph)
      PH_LEAD:   begin ones = 1'b1; len = CNT_W'(LEAD_N);  end
      PH_TRAIL:  begin ones = 1'b1; len = CNT_W'(TRAIL_N); end
      PH_IDSTOP,
      PH_FSTOP:  begin ones = 1'b1; len = CNT_W'(STOP_N);  end
      PH_POST:   begin ones = 1'b1; len = CNT_W'(POST_N);  end
      PH_HDR: begin
        vec[VEC_W-1 -: HDR_VEC_W] = {PREAMBLE, cfg_len};
        len = CNT_W'(HDR_VEC_W);
      end
      PH_ID: begin
        vec[VEC_W-1 -: ID_FRAME_W] =
          {1'b0, 1'b1, 1'b0, id_par, ID_ADDR, cfg_pe, {ID_RSV_W{1'b0}}, cfg_id};
        len = CNT_W'(ID_FRAME_W);
      end
      PH_FRAME: begin
        if (req_comp) begin
          vec[VEC_W-1 -: HEAD_W] = fr_head;
          len = CNT_W'(HEAD_W);
        end else begin
          vec[VEC_W-1 -: FULL_W] = {fr_head, {ALIGN_N{1'b0}}, 1'b1, req_data};
          len = CNT_W'(FULL_W);
        end
      end
      PH_END: begin
        vec[VEC_W-1 -: END_W] = END_WORD;
        len = CNT_W'(END_W);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cfg_bit_shift.sv
module cfg_bit_shift #(
  parameter int VEC_W = 80,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VEC_W-1:0] ld_vec,
  input  logic [CNT_W-1:0] ld_len,
  input  logic             ld_ones,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic             seg_done
);
  logic [VEC_W-1:0] vec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ones_q;
  logic             fire;

  assign out_valid = (cnt_q != '0);
  assign out_bit   = (!out_valid || ones_q) ? 1'b1 : vec_q[VEC_W-1];
  assign fire      = out_valid && out_ready;
  assign seg_done  = fire && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      cnt_q  <= '0;
      ones_q <= 1'b0;
    end else if (load) begin
      vec_q  <= ld_vec;
      cnt_q  <= ld_len;
      ones_q <= ld_ones;
    end else if (fire) begin
      vec_q <= {vec_q[VEC_W-2:0], 1'b0};
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/cfg_gen_seq.sv
module cfg_gen_seq
  import cfg_gen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   id_en,
  input  logic   req_valid,
  input  logic   req_last,
  input  logic   seg_done,
  output phase_e nxt_phase,
  output logic   load,
  output logic   session_start,
  output logic   req_ready,
  output logic   done
);
  phase_e ph_q;
  logic   id_en_q;
  logic   last_q;
  logic   accept;

  assign req_ready     = (ph_q == PH_WAIT);
  assign accept        = req_ready && req_valid;
  assign session_start = (ph_q == PH_IDLE) && start;

  always_comb begin
    nxt_phase = ph_q;
    load      = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start)  begin nxt_phase = PH_LEAD;  load = 1'b1; end
      PH_WAIT: if (accept) begin nxt_phase = PH_FRAME; load = 1'b1; end
      default: if (seg_done) begin
        unique case (ph_q)
          PH_LEAD:   nxt_phase = PH_HDR;
          PH_HDR:    nxt_phase = PH_TRAIL;
          PH_TRAIL:  nxt_phase = id_en_q ? PH_ID : PH_WAIT;
          PH_ID:     nxt_phase = PH_IDSTOP;
          PH_IDSTOP: nxt_phase = PH_WAIT;
          PH_FRAME:  nxt_phase = PH_FSTOP;
          PH_FSTOP:  nxt_phase = last_q ? PH_END : PH_WAIT;
          PH_END:    nxt_phase = PH_POST;
          default:   nxt_phase = PH_IDLE;
        endcase
        load = (nxt_phase != PH_WAIT) && (nxt_phase != PH_IDLE);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      id_en_q <= 1'b0;
      last_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      ph_q <= nxt_phase;
      done <= (ph_q == PH_POST) && seg_done;
      if (session_start) id_en_q <= id_en;
      if (accept)        last_q  <= req_last;
    end
  end

endmodule

// File: rtl/cfg_stream_gen.sv
module cfg_stream_gen
  import cfg_gen_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ALIGN_N = 2,
  parameter int LEAD_N  = 4,
  parameter int TRAIL_N = 8,
  parameter int STOP_N  = 8,
  parameter int POST_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [23:0]       cfg_len,
  input  logic              cfg_id_en,
  input  logic [19:0]       cfg_id,
  input  logic              cfg_par_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [10:0]       req_addr,
  input  logic              req_comp,
  input  logic              req_last,
  input  logic [DATA_W-1:0] req_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic              done
);
  localparam int FULL_W = full_frame_len(DATA_W, ALIGN_N);
  localparam int VEC_W  = max2(ID_FRAME_W, FULL_W);
  localparam int RUN_MX = max2(max2(LEAD_N, TRAIL_N), max2(STOP_N, POST_N));
  localparam int CNT_W  = $clog2(max2(VEC_W, RUN_MX) + 1);

  if ((LEAD_N % 8) != 4)
    begin : g_bad_lead  $error("LEAD_N must be 8n+4"); end
  if (TRAIL_N < 8 || (TRAIL_N % 8) != 0)
    begin : g_bad_trail $error("TRAIL_N must be a positive multiple of 8"); end
  if (STOP_N < 8 || (STOP_N % 8) != 0)
    begin : g_bad_stop  $error("STOP_N must be a positive multiple of 8"); end
  if (ALIGN_N < 1 || POST_N < 1)
    begin : g_bad_misc  $error("ALIGN_N and POST_N must be at least 1"); end

  // named internal events
  phase_e           nxt_phase;
  logic             seg_load;
  logic             seg_done;
  logic             session_start;
  logic [VEC_W-1:0] bld_vec;
  logic [CNT_W-1:0] bld_len;
  logic             bld_ones;

  logic [LEN_W-1:0] len_q;
  logic [ID_W-1:0]  id_q;
  logic             pe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      id_q  <= '0;
      pe_q  <= 1'b0;
    end else if (session_start) begin
      len_q <= cfg_len;
      id_q  <= cfg_id;
      pe_q  <= cfg_par_en;
    end
  end

  cfg_gen_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (cfg_start),
    .id_en         (cfg_id_en),
    .req_valid     (req_valid),
    .req_last      (req_last),
    .seg_done      (seg_done),
    .nxt_phase     (nxt_phase),
    .load          (seg_load),
    .session_start (session_start),
    .req_ready     (req_ready),
    .done          (done)
  );

  cfg_frame_build #(
    .DATA_W (DATA_W), .ALIGN_N (ALIGN_N), .LEAD_N (LEAD_N),
    .TRAIL_N(TRAIL_N), .STOP_N (STOP_N),  .POST_N (POST_N),
    .VEC_W  (VEC_W),  .CNT_W  (CNT_W)
  ) u_build (
    .ph       (nxt_phase),
    .cfg_len  (len_q),
    .cfg_id   (id_q),
    .cfg_pe   (pe_q),
    .req_addr (req_addr),
    .req_comp (req_comp),
    .req_data (req_data),
    .vec      (bld_vec),
    .len      (bld_len),
    .ones     (bld_ones)
  );

  cfg_bit_shift #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (seg_load),
    .ld_vec    (bld_vec),
    .ld_len    (bld_len),
    .ld_ones   (bld_ones),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .seg_done  (seg_done)
  );

endmodule

// File: rtl/cfg_stream_gen_chk.sv
module cfg_stream_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic seg_done
);

  always @(negedge clk) begin
    if (!rst_n)
      assert_reset_state_R1: assert (!out_valid && out_bit && !req_ready && !done);
  end

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_bit);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid);

  assert_take_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (out_valid && !req_ready));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(seg_done));

endmodule

bind cfg_stream_gen cfg_stream_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .seg_done  (seg_done)
);

// File: tb/cfg_stream_gen_tb_top.sv
module cfg_stream_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 8;
  localparam int ALIGN_N = 3;
  localparam int LEAD_N  = 12;
  localparam int TRAIL_N = 16;
  localparam int STOP_N  = 8;
  localparam int POST_N  = 5;
  localparam int MAXF    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_start = 1'b0;
  logic [23:0] cfg_len = '0;
  logic cfg_id_en = 1'b0;
  logic [19:0] cfg_id = '0;
  logic cfg_par_en = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [10:0] req_addr = '0;
  logic req_comp = 1'b0;
  logic req_last = 1'b0;
  logic [DATA_W-1:0] req_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic out_bit;
  logic done;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_gen #(
    .DATA_W(DATA_W), .ALIGN_N(ALIGN_N), .LEAD_N(LEAD_N),
    .TRAIL_N(TRAIL_N), .STOP_N(STOP_N), .POST_N(POST_N)
  ) dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;

  bit    expq[$];
  string tagq[$];
  bit    gotq[$];
  bit    mon_on = 0;
  bit    rdy_rand = 0;
  bit    prev_stall = 0;
  bit    prev_bit = 1;
  int    idle_bad = 0;
  int    hold_bad = 0;
  int    done_cnt = 0;

  logic [10:0]       fa [MAXF];
  bit                fc [MAXF];
  logic [DATA_W-1:0] fd [MAXF];

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic put(input logic [63:0] v, input int w, input string t);
    for (int i = w - 1; i >= 0; i--) begin
      expq.push_back(v[i]);
      tagq.push_back(t);
    end
  endtask

  task automatic put_ones(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      expq.push_back(1'b1);
      tagq.push_back(t);
    end
  endtask

  function automatic int ones_in(input logic [63:0] v, input int w);
    int c = 0;
    for (int i = 0; i < w; i++) c += int'(v[i]);
    return c;
  endfunction

  // parity pair: odd bit then even bit
  function automatic logic [1:0] exp_par(input int ones, input bit pe);
    bit ev = ones[0];
    if (!pe) return 2'b00;
    return {!ev, ev};
  endfunction

  task automatic build_expected(input logic [23:0] len, input bit id_en,
                                input logic [19:0] id, input bit pe, input int nf);
    logic [1:0] p;
    expq.delete(); tagq.delete();
    put_ones(LEAD_N, "R2");
    put(64'b0010, 4, "R2");
    put(64'(len), 24, "R2");
    put_ones(TRAIL_N, "R2");
    if (id_en) begin
      p = exp_par(11 + int'(pe) + ones_in(64'(id), 20), pe);
      put(64'b010, 3, "R3");
      put(64'(p), 2, "R6");
      put_ones(11, "R3");
      put(64'(pe), 1, "R3");
      put(64'd0, 43, "R3");
      put(64'(id), 20, "R3");
      put_ones(STOP_N, "R7");
    end
    for (int f = 0; f < nf; f++) begin
      string t = fc[f] ? "R5" : "R4";
      p = exp_par(ones_in(64'(fa[f]), 11) + (fc[f] ? 0 : ones_in(64'(fd[f]), DATA_W)), pe);
      put({62'b01, fc[f]}, 3, t);
      put(64'(p), 2, "R6");
      put(64'(fa[f]), 11, t);
      if (!fc[f]) begin
        put(64'd0, ALIGN_N, "R4");
        put(64'd1, 1, "R4");
        put(64'(fd[f]), DATA_W, "R4");
      end
      put_ones(STOP_N, "R7");
    end
    put(64'b0010011111111111, 16, "R7");
    put_ones(POST_N, "R7");
  endtask

  // monitor: drive sink ready, then sample away from the edge
  initial begin
    forever begin
      @(negedge clk);
      out_ready = rdy_rand ? 1'($urandom % 2) : 1'b1;
      #1;
      if (mon_on) begin
        if (!out_valid && !out_bit) idle_bad++;
        if (prev_stall && !(out_valid && out_bit == prev_bit)) hold_bad++;
        prev_stall = out_valid && !out_ready;
        prev_bit   = out_bit;
        if (out_valid && out_ready) gotq.push_back(out_bit);
        if (done) done_cnt++;
      end
    end
  end

  task automatic send_frame(input int f, input bit last);
    repeat ($urandom % 4) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_addr = fa[f]; req_comp = fc[f];
    req_data = fd[f]; req_last = last;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    req_valid = 1'b0;
    req_data = ~req_data;  // later changes must not matter
  endtask

  task automatic run_session(input string name, input logic [23:0] len, input bit id_en,
                             input logic [19:0] id, input bit pe, input int nf,
                             input bit inject);
    int wait_cyc;
    int first_bad;
    build_expected(len, id_en, id, pe, nf);
    gotq.delete();
    done_cnt = 0;
    @(negedge clk);
    cfg_start = 1'b1; cfg_len = len; cfg_id_en = id_en; cfg_id = id; cfg_par_en = pe;
    @(negedge clk);
    cfg_start = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(req_ready == 1'b0, "R9", {name, " ready low in header"}, req_ready, 0);
    for (int f = 0; f < nf; f++) begin
      send_frame(f, f == nf - 1);
      if (inject && f == 0) begin
        @(negedge clk);
        cfg_start = 1'b1; cfg_len = ~len; cfg_id_en = !id_en;
        @(negedge clk);
        cfg_start = 1'b0; cfg_len = len; cfg_id_en = id_en;
      end
    end
    wait_cyc = 0;
    while (done_cnt == 0 && wait_cyc < 4000) begin @(negedge clk); #2; wait_cyc++; end
    repeat (4) @(negedge clk);
    #2;
    check(done_cnt == 1, "R10", {name, " done pulses"}, done_cnt, 1);
    check(gotq.size() == expq.size(), "R7", {name, " stream length"}, gotq.size(), expq.size());
    first_bad = -1;
    for (int i = 0; i < expq.size() && i < gotq.size(); i++)
      if (first_bad < 0 && gotq[i] != expq[i]) first_bad = i;
    if (first_bad >= 0)
      check(0, tagq[first_bad], $sformatf("%s bit %0d", name, first_bad),
            gotq[first_bad], expq[first_bad]);
    else
      check(1, "R4", {name, " stream content"}, 0, 0);
    check(out_valid == 1'b0 && out_bit == 1'b1, "R8", {name, " quiet after done"},
          {out_valid, out_bit}, 2'b01);
  endtask

  task automatic rand_frames(input int nf, input int comp_mode);
    for (int f = 0; f < nf; f++) begin
      fa[f] = 11'($urandom);
      fd[f] = DATA_W'($urandom);
      fc[f] = (comp_mode == 2) ? 1'($urandom % 2) : comp_mode[0];
    end
  endtask

  initial begin
    int seed;
    logic [7:0] pre_byte;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(out_bit == 1'b1, "R1", "out_bit in reset", out_bit, 1);
    check(req_ready == 1'b0, "R1", "req_ready in reset", req_ready, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;

    // directed: mixed frames, parity on, ID on, sink always ready
    fa[0] = 11'h000; fc[0] = 0; fd[0] = 8'hFF;
    fa[1] = 11'h7FF; fc[1] = 1; fd[1] = 8'h5A;
    fa[2] = 11'h123; fc[2] = 0; fd[2] = 8'h81;
    run_session("s1", 24'hA5_0F_3C, 1, 20'hC0FFE, 1, 3, 0);
    pre_byte = '0;
    for (int i = 0; i < 8 && (8 + i) < gotq.size(); i++) pre_byte = {pre_byte[6:0], gotq[8 + i]};
    check(pre_byte == 8'b11110010, "R2", "preamble byte", pre_byte, 8'b11110010);

    // parity off, stalling sink
    rdy_rand = 1;
    rand_frames(4, 2);
    run_session("s2", 24'h000001, 1, 20'h00001, 0, 4, 0);

    // no ID, all compressed, start injected mid-session
    rand_frames(3, 1);
    run_session("s3", 24'hFFFFFF, 0, 20'hFFFFF, 1, 3, 1);

    // single uncompressed frame, ID of all ones
    rand_frames(1, 0);
    run_session("s4", 24'h800000, 1, 20'hFFFFF, 1, 1, 0);

    for (int s = 0; s < 6; s++) begin
      rand_frames(1 + ($urandom % MAXF), 2);
      run_session($sformatf("r%0d", s), 24'($urandom), 1'($urandom % 2),
                  20'($urandom), 1'($urandom % 2), 1 + ($urandom % 3), 1'($urandom % 2));
    end

    check(idle_bad == 0, "R8", "line high while not valid", idle_bad, 0);
    check(hold_bad == 0, "R8", "bit held while stalled", hold_bad, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule